// File: doc/BRIEF.md
# Dual Event Counter with Interrupt Ticks

This block holds two event counters that work independently. Each one picks a single event from its own set of event inputs and adds it up. Each time a power-of-two number of events has built up, the counter raises a one-cycle interrupt tick and clears its integer part. Counter 0 can choose from nine events. Two of them, the issue event and the non-issue event, can add half a count in a cycle. Counter 1 can choose from eight events. The number of events between ticks is set by one rate bit per counter, and the two counters offer different pairs of periods.

A single configuration word holds the two rate bits, the two event selects and two mute bits. A write that would mute both counters is refused, and so is a write that selects an event code counter 0 does not have. A refused write leaves the stored word unchanged and raises a reject pulse. A muted counter keeps counting and keeps ticking, but each of its ticks carries a discard flag so the interrupt handler can throw it away. A global enable gates tick generation only; counting goes on while the enable is low.

Top module: `dual_event_ticker`

## Requirements
- R1: After reset, cfgQ is 0, both ticks, both discard flags and cfgReject are 0, and both counts are 0.
- R2: Counter 0 ticks when its integer count reaches 2^12 if cfg bit 0 is 1, and when it reaches 2^16 if cfg bit 0 is 0. The tick is high in the cycle after the edge that samples the last event.
- R3: Counter 1 ticks when its integer count reaches 2^8 if cfg bit 1 is 1, and when it reaches 2^12 if cfg bit 1 is 0. The timing is the same as for R2.
- R4: The configuration word has these fields: rate bits [1:0], counter 0 select [5:2], counter 1 select [8:6], and mute bits [10:9], with bit 9 for counter 0 and bit 10 for counter 1. A write with both mute bits set, or with a counter 0 select above 8, is refused. A refused write leaves cfgQ unchanged and makes cfgReject 1 for one cycle after the write edge.
- R5: Counter 0 select 0 is the issue event. It adds one count when issueCnt is 2 or more and half a count when issueCnt is 1. Select 7 is the non-issue event. It adds one count when issueCnt is 0 and half a count when issueCnt is 1.
- R6: Level events add exactly one count for each cycle in which they are high, not one per stretch of high cycles. These are dry pipe, frozen pipe, privileged mode and cycles (always high) on counter 0, and dual issue on counter 1.
- R7: Counter 0 selects are 1 dry pipe, 2 load, 3 frozen pipe, 4 branch, 5 cycles, 6 privileged mode and 8 external input 0. Counter 1 selects are 0 data-cache miss, 1 instruction-cache miss, 2 dual issue (issueCnt of 2 or more), 3 mispredict, 4 floating-point op, 5 integer op, 6 store and 7 external input 1. Inputs that are not selected have no effect.
- R8: A muted counter still ticks on schedule, and its discard flag is 1 in the same cycle as the tick. The flag is 0 for an unmuted counter.
- R9: While globalEn is 0, no tick is raised and counting continues. If the count has already reached the threshold when globalEn rises, the tick follows at the next edge.
- R10: On a tick, the integer count returns to 0 and any leftover half count is kept.
- R11: Each tick lasts one cycle, and activity on one counter never changes the count or ticks of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Enables tick generation |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgData | input | 11 | Configuration word to write |
| issueCnt | input | 2 | Instructions issued this cycle |
| pipeDry | input | 1 | Pipe dry this cycle |
| loadRet | input | 1 | Load instruction event |
| pipeFrozen | input | 1 | Pipe frozen this cycle |
| branchRet | input | 1 | Branch instruction event |
| privMode | input | 1 | Privileged mode cycle |
| extIn0 | input | 1 | External event input 0 |
| dcMiss | input | 1 | Data-cache miss event |
| icMiss | input | 1 | Instruction-cache miss event |
| brMiss | input | 1 | Mispredicted branch event |
| fpOp | input | 1 | Floating-point operate event |
| intOp | input | 1 | Integer operate event |
| storeRet | input | 1 | Store instruction event |
| extIn1 | input | 1 | External event input 1 |
| cfgQ | output | 11 | Stored configuration word |
| cfgReject | output | 1 | Pulse: last write was refused |
| tick0 | output | 1 | Counter 0 interrupt tick |
| tick1 | output | 1 | Counter 1 interrupt tick |
| drop0 | output | 1 | Counter 0 tick is to be discarded |
| drop1 | output | 1 | Counter 1 tick is to be discarded |
| count0 | output | 17 | Integer count of counter 0 |
| count1 | output | 17 | Integer count of counter 1 |

## Verification
Every result comes from exactly one register stage. A configuration write shows up on cfgQ and cfgReject right after the edge that samples it. An event shows up on the count right after the edge that samples it. A tick, together with its discard flag and its cleared count, shows up right after the edge that samples the event that reaches the threshold. The bench drives all inputs on the falling edge and reads the outputs on the next falling edge. This means every check falls half a period after the edge where its result is due. For the threshold tests, the bench counts the exact number of edges with the event held high. It checks that the count is one below the threshold with no tick, and then, one edge later, that the tick is present and the count is cleared.

// File: rtl/evtk_pkg.sv
package evtk_pkg;
  localparam int CFG_W    = 11;
  localparam int SEL0_W   = 4;
  localparam int SEL1_W   = 3;
  localparam int EVT0_N   = 9;
  localparam int EVT1_N   = 8;
  localparam int SEL0_ISSUE    = 0;
  localparam int SEL0_NONISSUE = 7;
  localparam int SEL1_DUAL     = 2;

  // Configuration word, MSB first: mute[10:9] sel1[8:6] sel0[5:2] fast[1:0]
  typedef struct packed {
    logic [1:0]        mute;
    logic [SEL1_W-1:0] sel1;
    logic [SEL0_W-1:0] sel0;
    logic [1:0]        fast;
  } cfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic              armed;
    logic [1:0]        fast;
    logic [1:0]        mute;
    logic [SEL0_W-1:0] sel0;
    logic [SEL1_W-1:0] sel1;
  } ctrlBus_t;
endpackage

// File: rtl/evtk_ctrl.sv
module evtk_ctrl
  import evtk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     globalEn,
  input  logic     cfgWrite,
  input  cfg_t     cfgData,
  output cfg_t     cfgQ,
  output logic     cfgReject,
  output ctrlBus_t bus
);
  logic illegal;

  assign illegal = (cfgData.mute == 2'b11) ||
                   (int'(cfgData.sel0) >= EVT0_N);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ      <= '0;
      cfgReject <= 1'b0;
    end else begin
      cfgReject <= cfgWrite && illegal;
      if (cfgWrite && !illegal) cfgQ <= cfgData;
    end
  end

  always_comb begin
    bus.armed = globalEn;
    bus.fast  = cfgQ.fast;
    bus.mute  = cfgQ.mute;
    bus.sel0  = cfgQ.sel0;
    bus.sel1  = cfgQ.sel1;
  end

  AST_REJECT_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    cfgReject |-> $stable(cfgQ)); // R4

  AST_NEVER_BOTH_MUTED: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.mute != 2'b11); // R4
endmodule

// File: rtl/evtk_slice.sv
module evtk_slice #(
  parameter int FAST_LOG = 12,
  parameter int SLOW_LOG = 16,
  parameter int CNT_W    = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armed,
  input  logic             fast,
  input  logic             mute,
  input  logic [1:0]       step,
  output logic             tick,
  output logic             drop,
  output logic [CNT_W-1:0] count
);
  localparam int ACC_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] THR_FAST = ONE << FAST_LOG;
  localparam logic [CNT_W-1:0] THR_SLOW = ONE << SLOW_LOG;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accSum;
  logic [ACC_W:0]   wide;
  logic [CNT_W-1:0] thr;
  logic             hit;

  assign thr    = fast ? THR_FAST : THR_SLOW;
  assign wide   = {1'b0, acc} + {{(ACC_W-1){1'b0}}, step};
  assign accSum = wide[ACC_W] ? '1 : wide[ACC_W-1:0];
  assign hit    = armed && (accSum[ACC_W-1:1] >= thr);
  assign count  = acc[ACC_W-1:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc  <= '0;
      tick <= 1'b0;
      drop <= 1'b0;
    end else begin
      tick <= hit;
      drop <= hit && mute;
      acc  <= hit ? {{(ACC_W-1){1'b0}}, accSum[0]} : accSum;
    end
  end

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R11

  AST_DROP_WITH_TICK: assert property (@(posedge clk) disable iff (!rstN)
    drop |-> tick); // R8

  AST_CLEAR_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (count == '0)); // R10

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> $past(armed)); // R9
endmodule

// File: rtl/evtk_datapath.sv
module evtk_datapath
  import evtk_pkg::*;
#(
  parameter int C0_FAST_LOG = 12,
  parameter int C0_SLOW_LOG = 16,
  parameter int C1_FAST_LOG = 8,
  parameter int C1_SLOW_LOG = 12,
  parameter int CNT_W       = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlBus_t          bus,
  input  logic [1:0]        issueCnt,
  input  logic [EVT0_N-1:0] lvl0,
  input  logic [EVT1_N-1:0] lvl1,
  output logic [1:0]        tick,
  output logic [1:0]        drop,
  output logic [CNT_W-1:0]  count0,
  output logic [CNT_W-1:0]  count1
);
  localparam int SEL0_N = 1 << SEL0_W;

  logic [SEL0_N-1:0] lvl0Ext;
  logic [1:0]        step [2];
  logic [CNT_W-1:0]  cnt  [2];

  assign lvl0Ext = {{(SEL0_N-EVT0_N){1'b0}}, lvl0};

  always_comb begin
    if (int'(bus.sel0) == SEL0_ISSUE)
      step[0] = (issueCnt >= 2'd2) ? 2'd2 : ((issueCnt == 2'd1) ? 2'd1 : 2'd0);
    else if (int'(bus.sel0) == SEL0_NONISSUE)
      step[0] = (issueCnt == 2'd0) ? 2'd2 : ((issueCnt == 2'd1) ? 2'd1 : 2'd0);
    else
      step[0] = {lvl0Ext[bus.sel0], 1'b0};

    if (int'(bus.sel1) == SEL1_DUAL)
      step[1] = (issueCnt >= 2'd2) ? 2'd2 : 2'd0;
    else
      step[1] = {lvl1[bus.sel1], 1'b0};
  end

  for (genvar i = 0; i < 2; i++) begin : g_slice
    evtk_slice #(
      .FAST_LOG((i == 0) ? C0_FAST_LOG : C1_FAST_LOG),
      .SLOW_LOG((i == 0) ? C0_SLOW_LOG : C1_SLOW_LOG),
      .CNT_W   (CNT_W)
    ) u_slice (
      .clk  (clk),
      .rstN (rstN),
      .armed(bus.armed),
      .fast (bus.fast[i]),
      .mute (bus.mute[i]),
      .step (step[i]),
      .tick (tick[i]),
      .drop (drop[i]),
      .count(cnt[i])
    );
  end

  assign count0 = cnt[0];
  assign count1 = cnt[1];
endmodule

// File: rtl/dual_event_ticker.sv
module dual_event_ticker
  import evtk_pkg::*;
#(
  parameter int C0_FAST_LOG = 12,
  parameter int C0_SLOW_LOG = 16,
  parameter int C1_FAST_LOG = 8,
  parameter int C1_SLOW_LOG = 12,
  localparam int MAX0  = (C0_FAST_LOG > C0_SLOW_LOG) ? C0_FAST_LOG : C0_SLOW_LOG,
  localparam int MAX1  = (C1_FAST_LOG > C1_SLOW_LOG) ? C1_FAST_LOG : C1_SLOW_LOG,
  localparam int CNT_W = ((MAX0 > MAX1) ? MAX0 : MAX1) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             globalEn,
  input  logic             cfgWrite,
  input  logic [10:0]      cfgData,
  input  logic [1:0]       issueCnt,
  input  logic             pipeDry,
  input  logic             loadRet,
  input  logic             pipeFrozen,
  input  logic             branchRet,
  input  logic             privMode,
  input  logic             extIn0,
  input  logic             dcMiss,
  input  logic             icMiss,
  input  logic             brMiss,
  input  logic             fpOp,
  input  logic             intOp,
  input  logic             storeRet,
  input  logic             extIn1,
  output logic [10:0]      cfgQ,
  output logic             cfgReject,
  output logic             tick0,
  output logic             tick1,
  output logic             drop0,
  output logic             drop1,
  output logic [CNT_W-1:0] count0,
  output logic [CNT_W-1:0] count1
);
  ctrlBus_t          bus;
  cfg_t              cfgReg;
  logic [EVT0_N-1:0] lvl0;
  logic [EVT1_N-1:0] lvl1;
  logic [1:0]        tickV;
  logic [1:0]        dropV;

  // Index = select code; issue-type codes are handled in the datapath
  assign lvl0 = {extIn0, 1'b0, privMode, 1'b1, branchRet, pipeFrozen, loadRet, pipeDry, 1'b0};
  assign lvl1 = {extIn1, storeRet, intOp, fpOp, brMiss, 1'b0, icMiss, dcMiss};

  evtk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .globalEn (globalEn),
    .cfgWrite (cfgWrite),
    .cfgData  (cfg_t'(cfgData)),
    .cfgQ     (cfgReg),
    .cfgReject(cfgReject),
    .bus      (bus)
  );

  evtk_datapath #(
    .C0_FAST_LOG(C0_FAST_LOG),
    .C0_SLOW_LOG(C0_SLOW_LOG),
    .C1_FAST_LOG(C1_FAST_LOG),
    .C1_SLOW_LOG(C1_SLOW_LOG),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .bus     (bus),
    .issueCnt(issueCnt),
    .lvl0    (lvl0),
    .lvl1    (lvl1),
    .tick    (tickV),
    .drop    (dropV),
    .count0  (count0),
    .count1  (count1)
  );

  assign cfgQ  = cfgReg;
  assign tick0 = tickV[0];
  assign tick1 = tickV[1];
  assign drop0 = dropV[0];
  assign drop1 = dropV[1];
endmodule

// File: tb/dual_event_ticker_test.sv
module dual_event_ticker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        globalEn = 1'b1;
  logic        cfgWrite = 1'b0;
  logic [10:0] cfgData = '0;
  logic [1:0]  issueCnt = '0;
  logic pipeDry = 0, loadRet = 0, pipeFrozen = 0, branchRet = 0, privMode = 0, extIn0 = 0;
  logic dcMiss = 0, icMiss = 0, brMiss = 0, fpOp = 0, intOp = 0, storeRet = 0, extIn1 = 0;
  logic [10:0] cfgQ;
  logic        cfgReject, tick0, tick1, drop0, drop1;
  logic [16:0] count0, count1;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_event_ticker uut (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .issueCnt(issueCnt), .pipeDry(pipeDry), .loadRet(loadRet), .pipeFrozen(pipeFrozen),
    .branchRet(branchRet), .privMode(privMode), .extIn0(extIn0), .dcMiss(dcMiss),
    .icMiss(icMiss), .brMiss(brMiss), .fpOp(fpOp), .intOp(intOp), .storeRet(storeRet),
    .extIn1(extIn1), .cfgQ(cfgQ), .cfgReject(cfgReject), .tick0(tick0), .tick1(tick1),
    .drop0(drop0), .drop1(drop1), .count0(count0), .count1(count1)
  );

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; globalEn = 1; cfgWrite = 0; cfgData = '0; issueCnt = 0;
    pipeDry = 0; loadRet = 0; pipeFrozen = 0; branchRet = 0; privMode = 0; extIn0 = 0;
    dcMiss = 0; icMiss = 0; brMiss = 0; fpOp = 0; intOp = 0; storeRet = 0; extIn1 = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic writeCfg(logic [10:0] v);
    cfgData = v; cfgWrite = 1;
    @(negedge clk);
    cfgWrite = 0;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 cfgQ", cfgQ, 0);
    chk("R1 ticks", {tick0, tick1, drop0, drop1, cfgReject}, 0);
    chk("R1 count0", count0, 0);
    chk("R1 count1", count1, 0);
  endtask

  task automatic testC0Fast();
    doReset();
    writeCfg(11'h011);            // fast0, sel0=4 branch
    branchRet = 1;
    repeat (4095) @(negedge clk);
    chk("R2 fast count before", count0, 4095);
    chk("R2 fast no tick", tick0, 0);
    @(negedge clk);
    chk("R2 fast tick", tick0, 1);
    chk("R8 no drop when unmuted", drop0, 0);
    chk("R10 count cleared", count0, 0);
    branchRet = 0;
    @(negedge clk);
    chk("R11 tick0 one cycle", tick0, 0);
  endtask

  task automatic testC0Slow();
    int seen = 0;
    doReset();
    writeCfg(11'h010);            // slow0, sel0=4 branch
    branchRet = 1;
    for (int k = 0; k < 65535; k++) begin
      @(negedge clk);
      if (tick0) seen++;
    end
    chk("R2 slow no early tick", seen, 0);
    chk("R2 slow count before", count0, 65535);
    @(negedge clk);
    chk("R2 slow tick", tick0, 1);
    branchRet = 0;
  endtask

  task automatic testC1();
    doReset();
    writeCfg(11'h002);            // fast1, sel1=0 dcache miss
    dcMiss = 1;
    repeat (255) @(negedge clk);
    chk("R3 fast count before", count1, 255);
    chk("R3 fast no tick", tick1, 0);
    @(negedge clk);
    chk("R3 fast tick", tick1, 1);
    dcMiss = 0;
    doReset();
    writeCfg(11'h040);            // slow1, sel1=1 icache miss
    icMiss = 1;
    repeat (4095) @(negedge clk);
    chk("R3 slow no tick", tick1, 0);
    @(negedge clk);
    chk("R3 slow tick", tick1, 1);
    icMiss = 0;
  endtask

  task automatic testHalfSteps();
    doReset();
    writeCfg(11'h001);            // sel0=0 issue
    issueCnt = 1;
    repeat (3) @(negedge clk);
    chk("R5 issue three singles", count0, 1);
    issueCnt = 2;
    @(negedge clk);
    chk("R5 issue dual adds one", count0, 2);
    issueCnt = 0;
    @(negedge clk);
    chk("R5 issue zero adds none", count0, 2);
    doReset();
    writeCfg(11'h01C);            // sel0=7 non-issue
    issueCnt = 0;
    repeat (2) @(negedge clk);
    chk("R5 nonissue zero", count0, 2);
    issueCnt = 1;
    @(negedge clk);
    chk("R5 nonissue half", count0, 2);
    @(negedge clk);
    chk("R5 nonissue two halves", count0, 3);
    issueCnt = 2;
    repeat (3) @(negedge clk);
    chk("R5 nonissue dual none", count0, 3);
    issueCnt = 0;
  endtask

  task automatic testResidual();
    doReset();
    writeCfg(11'h001);            // fast0, issue
    issueCnt = 1;
    @(negedge clk);
    issueCnt = 2;
    repeat (4095) @(negedge clk);
    chk("R10 count before", count0, 4095);
    @(negedge clk);
    chk("R10 tick with half left", tick0, 1);
    chk("R10 integer cleared", count0, 0);
    issueCnt = 1;
    @(negedge clk);
    chk("R10 half kept", count0, 1);
    issueCnt = 0;
  endtask

  task automatic testLevels();
    doReset();
    writeCfg(11'h08C);            // sel0=3 frozen, sel1=2 dual
    pipeFrozen = 1;
    repeat (10) @(negedge clk);
    pipeFrozen = 0;
    chk("R6 frozen per cycle", count0, 10);
    issueCnt = 2;
    repeat (3) @(negedge clk);
    issueCnt = 1;
    repeat (2) @(negedge clk);
    issueCnt = 0;
    chk("R6 dual issue per cycle", count1, 3);
    chk("R7 dual not on counter0", count0, 10);
  endtask

  task automatic testSelects();
    doReset();
    writeCfg(11'h1E0);            // sel0=8 ext0, sel1=7 ext1
    loadRet = 1; dcMiss = 1; storeRet = 1; branchRet = 1;
    repeat (4) @(negedge clk);
    loadRet = 0; dcMiss = 0; storeRet = 0; branchRet = 0;
    chk("R7 unselected counter0", count0, 0);
    chk("R7 unselected counter1", count1, 0);
    extIn0 = 1; extIn1 = 1;
    repeat (5) @(negedge clk);
    extIn1 = 0;
    repeat (2) @(negedge clk);
    extIn0 = 0;
    chk("R7 ext0 selected", count0, 7);
    chk("R7 ext1 selected", count1, 5);
  endtask

  task automatic testMute();
    doReset();
    writeCfg(11'h402);            // fast1, mute counter1
    dcMiss = 1;
    repeat (256) @(negedge clk);
    dcMiss = 0;
    chk("R8 muted still ticks", tick1, 1);
    chk("R8 discard flag", drop1, 1);
    chk("R8 other flag clear", drop0, 0);
  endtask

  task automatic testReject();
    doReset();
    writeCfg(11'h011);
    chk("R4 accepted", cfgQ, 11'h011);
    chk("R4 no reject", cfgReject, 0);
    writeCfg(11'h600);
    chk("R4 both muted refused", cfgReject, 1);
    chk("R4 cfg kept", cfgQ, 11'h011);
    writeCfg(11'h024);
    chk("R4 bad select refused", cfgReject, 1);
    chk("R4 cfg kept again", cfgQ, 11'h011);
    writeCfg(11'h200);
    chk("R4 single mute accepted", cfgQ, 11'h200);
    chk("R4 reject cleared", cfgReject, 0);
  endtask

  task automatic testGlobalEn();
    int seen = 0;
    doReset();
    globalEn = 0;
    writeCfg(11'h002);
    dcMiss = 1;
    for (int k = 0; k < 260; k++) begin
      @(negedge clk);
      if (tick1) seen++;
    end
    dcMiss = 0;
    chk("R9 no tick while disabled", seen, 0);
    chk("R9 counting continues", count1, 260);
    globalEn = 1;
    @(negedge clk);
    chk("R9 tick on enable", tick1, 1);
    chk("R9 count cleared", count1, 0);
  endtask

  task automatic testIndependence();
    doReset();
    writeCfg(11'h013);            // fast0 branch, fast1 dcache
    branchRet = 1; dcMiss = 1;
    repeat (256) @(negedge clk);
    branchRet = 0; dcMiss = 0;
    chk("R11 counter1 ticks", tick1, 1);
    chk("R11 counter0 no tick", tick0, 0);
    chk("R11 counter0 untouched", count0, 256);
  endtask

  initial begin
    testReset();
    testReject();
    testC0Fast();
    testC0Slow();
    testC1();
    testHalfSteps();
    testResidual();
    testLevels();
    testSelects();
    testMute();
    testGlobalEn();
    testIndependence();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule